// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two N-bit two's complement numbers over several clock cycles. It uses radix-2 Booth recoding. The pair made of the lowest bit of the multiplier register and a one-bit history flop selects one of three actions on the accumulator: add the multiplicand, subtract it, or leave the accumulator alone. After that action, the accumulator, the multiplier register and the history flop move right by one position as a single arithmetic shift. Because of this, long runs of equal multiplier bits cost no adder work. The pair 1 then 0, seen as one run of ones begins, triggers a subtract. The pair 0 then 1, seen as the run ends, triggers an add.

A client raises `start_i` for one cycle with both operands present. The block then runs its iterations with `busy_o` high, pulses `done_o` for one cycle, and holds the 2N-bit product until the next accepted start. The block also counts the add and subtract operations it performs, which shows how well the recoding worked on a given multiplier. An optional mode treats the multiplier as a one's complement value and applies one extra correction step.

Top module: `booth_mult`

## Requirements
- R1: `start_i` is accepted when the block is idle or in its `done_o` cycle. The operands and the mode are captured at that edge. The accumulator and history bit are cleared, and `busy_o` is high in the following cycle.
- R2: With the mode low, `product_o` equals the signed product of `mcand_i` and `mplier_i`, both read as two's complement. This holds at every extreme. For example, with N=8, the patterns 200 × 150 give +5936, 6 × −7 gives −42, and −128 × −128 gives +16384.
- R3: The recoding is done on each (current multiplier bit, history bit) pair. The pair 1,0 subtracts, 0,1 adds, and 1,1 or 0,0 leave the accumulator unchanged. `op_count_o` equals the number of 0/1 transitions when the multiplier is scanned from bit 0 upward, starting from an implicit 0. With N=16, 0x0FF0 costs 2 operations and 0x5555 costs 16.
- R4: `done_o` is high after the (2N+1)-th rising edge, counting the accepting edge as the first. When a correction step is taken, it is high after the (2N+2)-th edge.
- R5: `done_o` lasts exactly one cycle and is never high together with `busy_o`.
- R6: A `start_i` that arrives while `busy_o` is high is ignored. The result and the latency of the run in flight do not change.
- R7: `product_o` and `op_count_o` hold their values from `done_o` until the next accepted start, even when the operand inputs change.
- R8: When `ones_mode_i` is high at the accepting edge and the multiplier's top bit is set, the multiplier is read as one's complement. The result is then mcand × (mplier_as_two's_complement + 1), and it takes one extra cycle. A multiplier with its top bit clear behaves as in R2 and R4.
- R9: After reset, `busy_o` and `done_o` are low, and `product_o` and `op_count_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a multiplication |
| mcand_i | input | N | Multiplicand, two's complement |
| mplier_i | input | N | Multiplier, two's complement or one's complement |
| ones_mode_i | input | 1 | Treat the multiplier as one's complement |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle pulse when the product is valid |
| product_o | output | 2N | Signed product |
| op_count_o | output | clog2(N+1) | Number of add/subtract operations in the last run |

## Verification
Two functions of this block can fall in the same clock cycle: the one-cycle completion pulse of one run, and the acceptance of the next start. The bench provokes this by raising `start_i` in the exact cycle where `done_o` is seen. It then checks that the first product was presented correctly, that the second run reports its own product and operation count, and that the second run has full latency counted from that edge. A related collision, a start arriving during the iterations, is provoked by holding `start_i` high with different operands for several busy cycles. That test is judged by an unchanged product and latency.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_SHIFT,
        ST_FIX,
        ST_DONE
    } booth_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_ADD,
        OP_SUB
    } booth_op_e;

    typedef struct packed {
        logic load;
        logic arith;
        logic shift;
        logic fix;
    } booth_ctrl_t;

    function automatic booth_op_e pair_to_op(input logic cur, input logic prev);
        booth_op_e r;
        case ({cur, prev})
            2'b10:   r = OP_SUB;
            2'b01:   r = OP_ADD;
            default: r = OP_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_pkg::*;
(
    input  logic      cur_i,
    input  logic      prev_i,
    output booth_op_e op_o
);
    always_comb op_o = pair_to_op(cur_i, prev_i);
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        fix_req_i,
    output booth_ctrl_t ctrl_o,
    output logic        busy_o,
    output logic        done_o
);
    localparam int IW = (N > 2) ? $clog2(N) : 1;
    localparam logic [IW-1:0] LAST_ITER = IW'(N - 1);

    booth_state_e state_q, state_d;
    logic [IW-1:0] iter_q;
    logic          accept;

    assign accept = start_i && (state_q == ST_IDLE || state_q == ST_DONE);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (accept) state_d = ST_EVAL;
            ST_EVAL:  state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (iter_q == LAST_ITER) state_d = fix_req_i ? ST_FIX : ST_DONE;
                else                     state_d = ST_EVAL;
            end
            ST_FIX:   state_d = ST_DONE;
            ST_DONE:  state_d = accept ? ST_EVAL : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept)
                iter_q <= '0;
            else if (state_q == ST_SHIFT && iter_q != LAST_ITER)
                iter_q <= iter_q + 1'b1;
        end
    end

    always_comb begin
        ctrl_o.load  = accept;
        ctrl_o.arith = (state_q == ST_EVAL);
        ctrl_o.shift = (state_q == ST_SHIFT);
        ctrl_o.fix   = (state_q == ST_FIX);
    end

    assign busy_o = (state_q == ST_EVAL) || (state_q == ST_SHIFT) || (state_q == ST_FIX);
    assign done_o = (state_q == ST_DONE);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R5
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done_o && busy_o));

    // R6
    start_busy_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EVAL && start_i) |=> (state_q == ST_SHIFT));

    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);
endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  booth_ctrl_t      ctrl_i,
    input  booth_op_e        op_i,
    input  logic [N-1:0]     mcand_i,
    input  logic [N-1:0]     mplier_i,
    input  logic             ones_mode_i,
    output logic             cur_bit_o,
    output logic             hist_bit_o,
    output logic             fix_req_o,
    output logic [2*N-1:0]   product_o,
    output logic [$clog2(N+1)-1:0] op_count_o
);
    localparam int CW = $clog2(N + 1);
    localparam int PW = 2 * N;

    logic [N:0]    acc_q;
    logic [N-1:0]  mq_q;
    logic          hist_q;
    logic [N-1:0]  mc_q;
    logic          fix_q;
    logic [CW-1:0] ops_q;

    logic [N:0]    mc_ext;
    logic [N:0]    acc_sum;
    logic [PW-1:0] fix_sum;

    assign mc_ext  = {mc_q[N-1], mc_q};
    assign acc_sum = (op_i == OP_SUB) ? (acc_q - mc_ext) : (acc_q + mc_ext);
    assign fix_sum = {acc_q[N-1:0], mq_q} + {{N{mc_q[N-1]}}, mc_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            mq_q   <= '0;
            hist_q <= 1'b0;
            mc_q   <= '0;
            fix_q  <= 1'b0;
            ops_q  <= '0;
        end else if (ctrl_i.load) begin
            acc_q  <= '0;
            mq_q   <= mplier_i;
            hist_q <= 1'b0;
            mc_q   <= mcand_i;
            fix_q  <= ones_mode_i && mplier_i[N-1];
            ops_q  <= '0;
        end else if (ctrl_i.arith) begin
            if (op_i != OP_NONE) begin
                acc_q <= acc_sum;
                ops_q <= ops_q + 1'b1;
            end
        end else if (ctrl_i.shift) begin
            acc_q  <= {acc_q[N], acc_q[N:1]};
            mq_q   <= {acc_q[0], mq_q[N-1:1]};
            hist_q <= mq_q[0];
        end else if (ctrl_i.fix) begin
            acc_q <= {fix_sum[PW-1], fix_sum[PW-1:N]};
            mq_q  <= fix_sum[N-1:0];
        end
    end

    assign cur_bit_o  = mq_q[0];
    assign hist_bit_o = hist_q;
    assign fix_req_o  = fix_q;
    assign product_o  = {acc_q[N-1:0], mq_q};
    assign op_count_o = ops_q;

    // R3
    equal_pair_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i.arith && (mq_q[0] == hist_q)) |=> $stable(acc_q));

    // R3
    op_count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ops_q <= CW'(N));

    // R1
    load_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_i.load |=> (acc_q == '0 && !hist_q && ops_q == '0));

    // R3
    shift_history_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_i.shift |=> (hist_q == $past(mq_q[0])));
endmodule

// File: rtl/booth_mult.sv
module booth_mult
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic [N-1:0]            mcand_i,
    input  logic [N-1:0]            mplier_i,
    input  logic                    ones_mode_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [2*N-1:0]          product_o,
    output logic [$clog2(N+1)-1:0]  op_count_o
);
    booth_ctrl_t ctrl;
    booth_op_e   op;
    logic        cur_bit, hist_bit, fix_req;

    booth_ctrl #(.N(N)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .fix_req_i (fix_req),
        .ctrl_o    (ctrl),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    booth_recoder rec_i (
        .cur_i  (cur_bit),
        .prev_i (hist_bit),
        .op_o   (op)
    );

    booth_datapath #(.N(N)) dp_i (
        .clk         (clk),
        .rst         (rst),
        .ctrl_i      (ctrl),
        .op_i        (op),
        .mcand_i     (mcand_i),
        .mplier_i    (mplier_i),
        .ones_mode_i (ones_mode_i),
        .cur_bit_o   (cur_bit),
        .hist_bit_o  (hist_bit),
        .fix_req_o   (fix_req),
        .product_o   (product_o),
        .op_count_o  (op_count_o)
    );

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !ctrl.load) |=> ($stable(product_o) && $stable(op_count_o)));
endmodule

// File: tb/booth_mult_tb.sv
module booth_mult_tb_top;
    localparam int N  = 8;
    localparam int W  = 16;
    localparam int NV = 13;

    // {ones_mode, mcand, mplier, expected product}
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 8'h06, 8'hF9, 16'hFFD6},
        {1'b0, 8'hC8, 8'h96, 16'h1730},
        {1'b0, 8'h80, 8'h80, 16'h4000},
        {1'b0, 8'h80, 8'h01, 16'hFF80},
        {1'b0, 8'h7F, 8'h80, 16'hC080},
        {1'b0, 8'h7F, 8'h7F, 16'h3F01},
        {1'b0, 8'h00, 8'h55, 16'h0000},
        {1'b0, 8'hFF, 8'hFF, 16'h0001},
        {1'b0, 8'h0D, 8'hAA, 16'hFBA2},
        {1'b1, 8'h05, 8'hFE, 16'hFFFB},
        {1'b1, 8'h05, 8'hFF, 16'h0000},
        {1'b1, 8'hF9, 8'h03, 16'hFFEB},
        {1'b1, 8'h80, 8'h80, 16'h3F80}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic         start = 1'b0, mode = 1'b0;
    logic [N-1:0] a = '0, b = '0;
    logic         busy, done;
    logic [15:0]  prod;
    logic [3:0]   ops;

    logic         s_start = 1'b0;
    logic [W-1:0] s_a = '0, s_b = '0;
    logic         s_busy, s_done;
    logic [31:0]  s_prod;
    logic [4:0]   s_ops;

    booth_mult #(.N(N)) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .mcand_i(a), .mplier_i(b),
        .ones_mode_i(mode), .busy_o(busy), .done_o(done),
        .product_o(prod), .op_count_o(ops)
    );

    booth_mult #(.N(W)) dut_w_i (
        .clk(clk), .rst(rst), .start_i(s_start), .mcand_i(s_a), .mplier_i(s_b),
        .ones_mode_i(1'b0), .busy_o(s_busy), .done_o(s_done),
        .product_o(s_prod), .op_count_o(s_ops)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_ops(input logic [15:0] v, input int n);
        int c = 0;
        logic p = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (v[i] != p) c++;
            p = v[i];
        end
        return c;
    endfunction

    task automatic kick(input logic m, input logic [7:0] x, input logic [7:0] y);
        mode = m; a = x; b = y; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_done(inout int lat);
        while (!done && lat < 100) begin
            @(posedge clk); #1;
            lat++;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [15:0] keep;
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        check(!busy && !done, "R9", "busy/done after reset", {busy, done}, 0);
        check(prod == 0 && ops == 0, "R9", "product/count after reset", prod, 0);
        rst = 1'b0;
        @(posedge clk); #1;

        for (int i = 0; i < NV; i++) begin
            logic m;
            logic [7:0] x, y;
            logic [15:0] e;
            int el;
            {m, x, y, e} = VEC[i];
            kick(m, x, y);
            // R1 busy after accept
            check(busy, "R1", "busy after accept", busy, 1);
            lat = 1;
            wait_done(lat);
            el = (m && y[7]) ? 2 * N + 2 : 2 * N + 1;
            // R2 / R8 product
            check(prod == e, m ? "R8" : "R2", "product", prod, e);
            // R4 latency
            check(lat == el, "R4", "latency", lat, el);
            // R3 operation count
            check(int'(ops) == exp_ops({8'h00, y}, N), "R3", "op count", ops, exp_ops({8'h00, y}, N));
            // R5 one-cycle pulse
            @(posedge clk); #1;
            check(!done, "R5", "done cleared", done, 0);
        end

        // R6 start ignored while busy, operands change mid-run
        kick(1'b0, 8'h06, 8'hF9);
        lat = 1;
        repeat (2) begin @(posedge clk); #1; lat++; end
        a = 8'h11; b = 8'h22; start = 1'b1;
        repeat (3) begin @(posedge clk); #1; lat++; end
        start = 1'b0;
        wait_done(lat);
        check(prod == 16'hFFD6, "R6", "product with start while busy", prod, 16'hFFD6);
        check(lat == 2 * N + 1, "R6", "latency with start while busy", lat, 2 * N + 1);

        // R1 start in the done cycle is accepted (back to back)
        kick(1'b0, 8'h03, 8'h05);
        check(busy && !done, "R1", "back-to-back accept", {busy, done}, 2);
        lat = 1;
        wait_done(lat);
        check(prod == 16'h000F, "R1", "back-to-back product", prod, 16'h000F);
        check(lat == 2 * N + 1, "R4", "back-to-back latency", lat, 2 * N + 1);
        check(int'(ops) == exp_ops(16'h0005, N), "R3", "back-to-back op count", ops, exp_ops(16'h0005, N));

        // R7 hold after done while inputs change
        keep = prod;
        a = 8'h7F; b = 8'h81; mode = 1'b1;
        repeat (10) @(posedge clk);
        #1;
        check(prod == keep, "R7", "product held", prod, keep);
        check(int'(ops) == exp_ops(16'h0005, N), "R7", "op count held", ops, exp_ops(16'h0005, N));
        check(!busy && !done, "R7", "idle while held", {busy, done}, 0);

        // R3 run-length cost on the wide instance
        for (int k = 0; k < 2; k++) begin
            logic [15:0] y;
            logic [31:0] e;
            int ew;
            y = (k == 0) ? 16'h0FF0 : 16'h5555;
            e = (k == 0) ? 32'd12240 : 32'h0000AAAA;
            ew = (k == 0) ? 2 : 16;
            s_a = (k == 0) ? 16'd3 : 16'd2;
            s_b = y; s_start = 1'b1;
            @(posedge clk); #1;
            s_start = 1'b0;
            lat = 1;
            while (!s_done && lat < 100) begin @(posedge clk); #1; lat++; end
            check(int'(s_ops) == ew, "R3", "wide op count", s_ops, ew);
            check(s_prod == e, "R2", "wide product", s_prod, e);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule